// File: doc/BRIEF.md
# ADC Sample to Single-Precision Float Converter

This block turns one unsigned analog-to-digital sample word into a 32-bit IEEE-754 single-precision value. Arithmetic units further down the data path can then take measurement data without any fixed-point scaling. A sample arrives with a valid strobe. One clock later the encoded word appears with its own valid strobe.

The magnitude is at most 10 bits wide, so it always fits the 23-bit fraction field and every conversion is exact. The block finds the most significant set bit and takes the exponent from its position. The bits below that one move to the top of the fraction and zeros fill the rest. A separate sign input marks the sample as negative. A zero sample yields a signed zero and does not use the search result. There is no rounding, overflow, denormal or NaN logic.

Top module: `adc_to_float`

## Requirements
- R1: For a nonzero sample whose highest set bit is at position L (bit 0 being the least significant), the exponent field out_word[30:23] equals L + 127.
- R2: For a nonzero sample, out_word[22:0] holds the sample bits below position L, left-justified with bit L-1 at out_word[22], and zeros in every lower bit.
- R3: A zero sample gives an exponent field of 0 and a fraction field of 0.
- R4: The sign bit out_word[31] equals in_neg as captured with the sample, and is 0 whenever in_neg is low.
- R5: A zero sample with in_neg high gives 0x80000000, which differs from positive zero only in bit 31.
- R6: out_valid is high in exactly the cycle that follows a clock edge where in_valid was high, and low otherwise. The result of a sample is on out_word in that same cycle.
- R7: A synchronous active-high reset clears out_valid and out_word to 0.
- R8: While in_valid is low, out_word keeps its last value, whatever in_code and in_neg do.
- R9: Reference codes convert as follows: 0x05B gives 0x42B60000, 0x001 gives 0x3F800000 (1.0), and 0x3FF gives 0x447FC000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_code | input | 10 | Unsigned sample magnitude |
| in_neg | input | 1 | Marks the sample as negative |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 32 | Single-precision result |

## Verification
The leading-one search is the only internal state that can go wrong in a hidden way. If it settles on the wrong position, the exponent and the fraction shift together. Either corrupts out_word in the cycle right after the sample, so sweeping all 1024 codes against an independent double-precision reference exposes any wrong search result within one clock. A capture register that loads on the wrong condition shows up in the first idle cycle after a conversion, when out_word changes without a strobe.

// File: rtl/adc_to_float.sv
module adc_to_float #(
  parameter int IN_W  = 10,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [IN_W-1:0]            in_code,
  input  logic                       in_neg,
  output logic                       out_valid,
  output logic [EXP_W+MAN_W:0]       out_word
);

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int OUT_W = 1 + EXP_W + MAN_W;
  localparam int POS_W = (IN_W > 1) ? $clog2(IN_W) : 1;
  localparam int SH_W  = $clog2(MAN_W + 1);

  logic [POS_W-1:0] lead;
  logic             nonzero;
  logic [MAN_W:0]   wide;
  logic [MAN_W:0]   shifted;
  logic [SH_W-1:0]  shamt;
  logic [EXP_W-1:0] exp_c;
  logic [MAN_W-1:0] man_c;

  always_comb begin
    lead = '0;
    for (int i = 0; i < IN_W; i++)
      if (in_code[i]) lead = POS_W'(i);
  end

  assign nonzero = |in_code;
  assign wide    = {{(MAN_W + 1 - IN_W){1'b0}}, in_code};
  assign shamt   = SH_W'(MAN_W) - SH_W'(lead);
  assign shifted = wide << shamt;
  assign exp_c   = nonzero ? EXP_W'(BIAS) + EXP_W'(lead) : '0;
  assign man_c   = nonzero ? shifted[MAN_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {in_neg, exp_c, man_c};
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word)); // R8
  AST_ZERO_ENC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == '0) |=> (out_word[OUT_W-2:0] == '0)); // R3
  AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[OUT_W-1] == $past(in_neg))); // R4
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code != '0) |=>
      (out_word[OUT_W-2:MAN_W] >= EXP_W'(BIAS) &&
       out_word[OUT_W-2:MAN_W] <= EXP_W'(BIAS + IN_W - 1))); // R1

endmodule

// File: tb/sim_adc_to_float.sv
module sim_adc_to_float;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [42:0] VEC [NVEC] = '{
    {10'h05B, 1'b0, 32'h42B60000},
    {10'h001, 1'b0, 32'h3F800000},
    {10'h3FF, 1'b0, 32'h447FC000},
    {10'h000, 1'b0, 32'h00000000},
    {10'h000, 1'b1, 32'h80000000},
    {10'h200, 1'b0, 32'h44000000},
    {10'h003, 1'b1, 32'hC0400000},
    {10'h2AA, 1'b0, 32'h442A8000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  in_code = '0;
  logic        in_neg = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  int checks = 0;
  int fails = 0;

  adc_to_float u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_neg(in_neg), .out_valid(out_valid), .out_word(out_word)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] ref_word(input logic [9:0] c, input logic n);
    logic [63:0] d;
    int e;
    if (c == '0) return {n, 31'b0};
    d = $realtobits(real'(c));
    e = int'(d[62:52]) - 1023 + 127;
    return {n, e[7:0], d[51:29]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [9:0] c, input logic n, input logic [31:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; in_neg = n;
    @(negedge clk);
    chk("R6 out_valid", {31'b0, out_valid}, 32'd1);
    chk(req, out_word, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R7 reset out_word", out_word, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      convert(VEC[i][42:33], VEC[i][32], VEC[i][31:0], "R9 R1 R2 R3 R4 R5 table");

    for (int c = 0; c < 1024; c++)
      convert(10'(c), c[3], ref_word(10'(c), c[3]), "R1 R2 R3 R4 sweep");

    convert(10'h05B, 1'b0, 32'h42B60000, "R9 before idle");
    @(negedge clk);
    in_valid = 1'b0; in_code = 10'h3FF; in_neg = 1'b1;
    @(negedge clk);
    chk("R6 idle out_valid", {31'b0, out_valid}, 32'd0);
    chk("R8 idle hold", out_word, 32'h42B60000);
    in_code = 10'h001; in_neg = 1'b0;
    @(negedge clk);
    chk("R8 idle hold again", out_word, 32'h42B60000);

    convert(10'h000, 1'b1, 32'h80000000, "R5 negative zero");
    convert(10'h000, 1'b0, 32'h00000000, "R3 positive zero");

    convert(10'h2AA, 1'b0, 32'h442A8000, "R2 before reset");
    rst = 1'b1;
    @(negedge clk);
    chk("R7 mid reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R7 mid reset out_word", out_word, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule